// File: doc/BRIEF.md
# Raster Position Interrupt Controller

This block watches the horizontal and vertical beam counters of a video timing chain. It raises two interrupt requests from them. The first is a vertical-blank interrupt toward the non-maskable input of the CPU. The second is a maskable interrupt that fires at a programmed beam position. The position can be a column on every line, a line, or one column on one line. The beam counters come from elsewhere. The block only compares them and keeps state. A standard/extended-line-count select (`pal_mode`) sets the last valid line. An overscan select moves the first blanking line from 225 to 240.

The CPU reaches the block through a small byte-wide register port. The bus is synchronous: a write or read strobe counts when it is high at a rising clock edge, and read data is combinational. Reading a flag register returns the flag and clears it at that edge. If a new set event arrives in the same cycle, the set wins.

There are three pairs of enumerated states:

| Machine | States | Transitions |
|---|---|---|
| Vertical phase | `VS_ACTIVE`, `VS_BLANK` | `VS_ACTIVE` moves to `VS_BLANK` when V equals the blank start line; `VS_BLANK` moves to `VS_ACTIVE` when V equals 0 |
| Horizontal phase | `HS_DISPLAY`, `HS_BLANK` | `HS_DISPLAY` moves to `HS_BLANK` when H ≥ 289; `HS_BLANK` moves to `HS_DISPLAY` when 18 ≤ H < 289 |
| IRQ arming | `ARM_WAIT`, `ARM_HELD` | `ARM_WAIT` moves to `ARM_HELD` when the match condition is true, and that move fires the IRQ; `ARM_HELD` moves to `ARM_WAIT` when the condition is false |

There are two resets. Power-on reset (`pwr_rst_n`) clears everything and loads both compare registers with 0x1FF. System reset (`sys_rst_n`) clears everything except the compare registers.

Top module: `raster_irq_ctrl`

## Requirements
- R1: The mode field is bits [1:0] of register 0. Bit 7 of register 0 is the NMI enable. With mode 00 the IRQ flag is never set.
- R2: With mode 01, the IRQ flag sets at the edge where V, sampled, first equals the V compare value.
- R3: With mode 10, the IRQ flag sets on every line at the edge where H first equals the H compare value.
- R4: With mode 11, the IRQ flag sets only when H equals the H compare value while V equals the V compare value.
- R5: A match condition that stays true sets the IRQ flag once. The condition must go false before the flag can set again.
- R6: An H compare value above 339 never matches. A V compare value above 261 (`pal_mode`=0) or above 311 (`pal_mode`=1) never matches.
- R7: The H compare value is written through registers 1 (bits 7:0) and 2 (bit 0). The V compare value is written through registers 3 (bits 7:0) and 4 (bit 0). Both hold 0x1FF after power-on reset and keep their value through system reset.
- R8: The NMI flag sets on entering vertical blank, when V equals 225 (or 240 with overscan set), whatever the enable is. `nmi_o` is high only while both the flag and the enable are set.
- R9: The NMI flag reads as bit 7 of register 5. A read of register 5 clears it. It also clears when vertical blank ends at V=0.
- R10: The IRQ flag reads as bit 7 of register 6 and drives `irq_o`. A read of register 6 clears both.
- R11: When a flag read falls in the same cycle as a set event for that flag, the flag ends up set.
- R12: Register 7 returns the vertical-blank state in bit 7 and the horizontal-blank state in bit 6. Both follow the phase machines, one edge behind the counters.
- R13: Either reset clears the enable register, both flags and both phase machines. All bits not listed above read as 0, and registers 0 to 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| hcnt | input | 9 | Horizontal beam counter |
| vcnt | input | 9 | Vertical beam counter |
| pal_mode | input | 1 | 1 selects the 312-line range, 0 the 262-line range |
| overscan | input | 1 | 1 moves blank start to line 240 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| nmi_o | output | 1 | Vertical-blank interrupt request, active high |
| irq_o | output | 1 | Beam-position interrupt request, active high |

## Verification
A flag read and a flag set can fall on the same clock edge, for both the NMI and the IRQ flag. The bench provokes this on purpose. It holds the read strobe on the cycle where the counters first reach the blank start line, or first reach the programmed column. Random traffic also produces such overlaps by chance. Both cases are judged by the flag staying set (`irq_o` high, or bit 7 set on a later read) instead of being lost to the clear.

// File: rtl/rpi_pkg.sv
`timescale 1ns/1ps
package rpi_pkg;
    typedef enum logic [2:0] {
        RA_ENABLE   = 3'd0,
        RA_HCMP_LO  = 3'd1,
        RA_HCMP_HI  = 3'd2,
        RA_VCMP_LO  = 3'd3,
        RA_VCMP_HI  = 3'd4,
        RA_NMI_FLAG = 3'd5,
        RA_IRQ_FLAG = 3'd6,
        RA_STATUS   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_VLINE = 2'b01,
        MODE_HDOT  = 2'b10,
        MODE_HV    = 2'b11
    } irq_mode_e;

    typedef enum logic { VS_ACTIVE, VS_BLANK }  vstate_e;
    typedef enum logic { HS_DISPLAY, HS_BLANK } hstate_e;
    typedef enum logic { ARM_WAIT, ARM_HELD }   arm_e;

    localparam int ENA_NMI_BIT = 7;
    localparam int FLAG_BIT    = 7;
endpackage

// File: rtl/rpi_regs.sv
`timescale 1ns/1ps
module rpi_regs
    import rpi_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             pwr_rst_n,
    input  logic             sys_rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             nmi_flag,
    input  logic             irq_flag,
    input  logic             vblank,
    input  logic             hblank,
    output logic [7:0]       bus_rdata,
    output logic             nmi_en,
    output irq_mode_e        irq_mode,
    output logic [CNT_W-1:0] htime,
    output logic [CNT_W-1:0] vtime,
    output logic             rd_nmi,
    output logic             rd_irq
);
    localparam int HI_W = CNT_W - 8;

    reg_addr_e sel;
    always_comb sel = reg_addr_e'(bus_addr);

    // Compare registers: only power-on reset touches them
    always_ff @(posedge clk) begin
        if (!pwr_rst_n) begin
            htime <= '1;
            vtime <= '1;
        end else if (bus_wr) begin
            unique case (sel)
                RA_HCMP_LO: htime[7:0]       <= bus_wdata;
                RA_HCMP_HI: htime[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
                RA_VCMP_LO: vtime[7:0]       <= bus_wdata;
                RA_VCMP_HI: vtime[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Enable register: cleared by either reset
    always_ff @(posedge clk) begin
        if (!pwr_rst_n || !sys_rst_n) begin
            nmi_en   <= 1'b0;
            irq_mode <= MODE_OFF;
        end else if (bus_wr && sel == RA_ENABLE) begin
            nmi_en   <= bus_wdata[ENA_NMI_BIT];
            irq_mode <= irq_mode_e'(bus_wdata[1:0]);
        end
    end

    always_comb begin
        rd_nmi = bus_rd && (sel == RA_NMI_FLAG);
        rd_irq = bus_rd && (sel == RA_IRQ_FLAG);
    end

    always_comb begin
        bus_rdata = 8'h00;
        unique case (sel)
            RA_NMI_FLAG: bus_rdata[FLAG_BIT] = nmi_flag;
            RA_IRQ_FLAG: bus_rdata[FLAG_BIT] = irq_flag;
            RA_STATUS:   bus_rdata[7:6]      = {vblank, hblank};
            default:     bus_rdata           = 8'h00;
        endcase
    end
endmodule

// File: rtl/rpi_beam.sv
`timescale 1ns/1ps
module rpi_beam
    import rpi_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int V_BLANK_STD = 225,
    parameter int V_BLANK_OVS = 240,
    parameter int H_BLANK_ON  = 289,
    parameter int H_BLANK_OFF = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] vcnt,
    input  logic             overscan,
    input  logic             rd_nmi,
    output logic             vblank,
    output logic             hblank,
    output logic             nmi_flag
);
    localparam logic [CNT_W-1:0] VS_STD = CNT_W'(V_BLANK_STD);
    localparam logic [CNT_W-1:0] VS_OVS = CNT_W'(V_BLANK_OVS);
    localparam logic [CNT_W-1:0] HB_ON  = CNT_W'(H_BLANK_ON);
    localparam logic [CNT_W-1:0] HB_OFF = CNT_W'(H_BLANK_OFF);

    vstate_e v_q, v_d;
    hstate_e h_q, h_d;
    logic    start_hit, end_hit, nmi_set, nmi_clr;

    always_comb begin
        start_hit = (vcnt == (overscan ? VS_OVS : VS_STD));
        end_hit   = (vcnt == '0);
    end

    // Vertical phase transitions
    always_comb begin
        v_d     = v_q;
        nmi_set = 1'b0;
        nmi_clr = rd_nmi;
        unique case (v_q)
            VS_ACTIVE: if (start_hit) begin
                v_d     = VS_BLANK;
                nmi_set = 1'b1;
            end
            VS_BLANK: if (end_hit) begin
                v_d     = VS_ACTIVE;
                nmi_clr = 1'b1;
            end
        endcase
    end

    // Horizontal phase transitions
    always_comb begin
        h_d = h_q;
        unique case (h_q)
            HS_DISPLAY: if (hcnt >= HB_ON) h_d = HS_BLANK;
            HS_BLANK:   if (hcnt >= HB_OFF && hcnt < HB_ON) h_d = HS_DISPLAY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= VS_ACTIVE;
            h_q <= HS_DISPLAY;
        end else begin
            v_q <= v_d;
            h_q <= h_d;
        end
    end

    // Flag: set event beats a clear from the bus
    always_ff @(posedge clk) begin
        if (rst)          nmi_flag <= 1'b0;
        else if (nmi_set) nmi_flag <= 1'b1;
        else if (nmi_clr) nmi_flag <= 1'b0;
    end

    always_comb begin
        vblank = (v_q == VS_BLANK);
        hblank = (h_q == HS_BLANK);
    end
endmodule

// File: rtl/rpi_irq.sv
`timescale 1ns/1ps
module rpi_irq
    import rpi_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int H_LAST      = 339,
    parameter int V_LAST_NTSC = 261,
    parameter int V_LAST_PAL  = 311
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] vcnt,
    input  logic             pal_mode,
    input  irq_mode_e        irq_mode,
    input  logic [CNT_W-1:0] htime,
    input  logic [CNT_W-1:0] vtime,
    input  logic             rd_irq,
    output logic             irq_flag
);
    localparam logic [CNT_W-1:0] HL  = CNT_W'(H_LAST);
    localparam logic [CNT_W-1:0] VLN = CNT_W'(V_LAST_NTSC);
    localparam logic [CNT_W-1:0] VLP = CNT_W'(V_LAST_PAL);

    arm_e arm_q, arm_d;
    logic h_hit, v_hit, cond, fire;

    always_comb begin
        h_hit = (htime <= HL) && (hcnt == htime);
        v_hit = (vtime <= (pal_mode ? VLP : VLN)) && (vcnt == vtime);
        unique case (irq_mode)
            MODE_OFF:   cond = 1'b0;
            MODE_VLINE: cond = v_hit;
            MODE_HDOT:  cond = h_hit;
            MODE_HV:    cond = h_hit && v_hit;
        endcase
    end

    always_comb begin
        arm_d = arm_q;
        fire  = 1'b0;
        unique case (arm_q)
            ARM_WAIT: if (cond) begin
                arm_d = ARM_HELD;
                fire  = 1'b1;
            end
            ARM_HELD: if (!cond) arm_d = ARM_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) arm_q <= ARM_WAIT;
        else     arm_q <= arm_d;
    end

    always_ff @(posedge clk) begin
        if (rst)         irq_flag <= 1'b0;
        else if (fire)   irq_flag <= 1'b1;
        else if (rd_irq) irq_flag <= 1'b0;
    end
endmodule

// File: rtl/raster_irq_ctrl.sv
`timescale 1ns/1ps
module raster_irq_ctrl
    import rpi_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int H_LAST      = 339,
    parameter int V_LAST_NTSC = 261,
    parameter int V_LAST_PAL  = 311,
    parameter int V_BLANK_STD = 225,
    parameter int V_BLANK_OVS = 240,
    parameter int H_BLANK_ON  = 289,
    parameter int H_BLANK_OFF = 18
) (
    input  logic             clk,
    input  logic             pwr_rst_n,
    input  logic             sys_rst_n,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] vcnt,
    input  logic             pal_mode,
    input  logic             overscan,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             nmi_o,
    output logic             irq_o
);
    logic             rst;
    logic             nmi_en, rd_nmi, rd_irq;
    logic             nmi_flag, irq_flag, vblank, hblank;
    irq_mode_e        irq_mode;
    logic [CNT_W-1:0] htime, vtime;

    always_comb rst = !pwr_rst_n || !sys_rst_n;

    rpi_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst_n(sys_rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .nmi_flag(nmi_flag), .irq_flag(irq_flag),
        .vblank(vblank), .hblank(hblank), .bus_rdata(bus_rdata),
        .nmi_en(nmi_en), .irq_mode(irq_mode), .htime(htime), .vtime(vtime),
        .rd_nmi(rd_nmi), .rd_irq(rd_irq)
    );

    rpi_beam #(
        .CNT_W(CNT_W), .V_BLANK_STD(V_BLANK_STD), .V_BLANK_OVS(V_BLANK_OVS),
        .H_BLANK_ON(H_BLANK_ON), .H_BLANK_OFF(H_BLANK_OFF)
    ) u_beam (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .overscan(overscan),
        .rd_nmi(rd_nmi), .vblank(vblank), .hblank(hblank), .nmi_flag(nmi_flag)
    );

    rpi_irq #(
        .CNT_W(CNT_W), .H_LAST(H_LAST),
        .V_LAST_NTSC(V_LAST_NTSC), .V_LAST_PAL(V_LAST_PAL)
    ) u_irq (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .pal_mode(pal_mode),
        .irq_mode(irq_mode), .htime(htime), .vtime(vtime), .rd_irq(rd_irq),
        .irq_flag(irq_flag)
    );

    always_comb begin
        nmi_o = nmi_flag & nmi_en;
        irq_o = irq_flag;
    end
endmodule

// File: rtl/raster_irq_ctrl_chk.sv
`timescale 1ns/1ps
module raster_irq_ctrl_chk #(
    parameter int CNT_W       = 9,
    parameter int H_LAST      = 339,
    parameter int V_BLANK_STD = 225,
    parameter int V_BLANK_OVS = 240
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_rd,
    input logic [2:0]       bus_addr,
    input logic [CNT_W-1:0] vcnt,
    input logic             overscan,
    input logic             nmi_flag,
    input logic             irq_o,
    input logic [1:0]       irq_mode,
    input logic [CNT_W-1:0] htime
);
    localparam logic [CNT_W-1:0] VS_STD = CNT_W'(V_BLANK_STD);
    localparam logic [CNT_W-1:0] VS_OVS = CNT_W'(V_BLANK_OVS);
    localparam logic [CNT_W-1:0] HL     = CNT_W'(H_LAST);

    a_r8_nmi_sets_at_blank_start: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_flag) |-> ($past(vcnt) == ($past(overscan) ? VS_OVS : VS_STD)));

    a_r9_nmi_clears_by_read_or_end: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_flag) |-> ($past(bus_rd && bus_addr == 3'd5) || $past(vcnt) == '0));

    a_r10_irq_drops_only_on_read: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(bus_rd && bus_addr == 3'd6));

    a_r1_mode_off_stays_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_mode == 2'b00 && !irq_o) |=> !irq_o);

    a_r6_h_out_of_range_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_mode == 2'b10 && htime > HL && !irq_o) |=> !irq_o);
endmodule

bind raster_irq_ctrl raster_irq_ctrl_chk #(
    .CNT_W(CNT_W), .H_LAST(H_LAST),
    .V_BLANK_STD(V_BLANK_STD), .V_BLANK_OVS(V_BLANK_OVS)
) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .vcnt(vcnt), .overscan(overscan), .nmi_flag(nmi_flag), .irq_o(irq_o),
    .irq_mode(irq_mode), .htime(htime)
);

// File: tb/sim_raster_irq_ctrl.sv
`timescale 1ns/1ps
module sim_raster_irq_ctrl;
    logic       clk = 1'b0;
    logic       pwr_rst_n = 1'b0, sys_rst_n = 1'b1;
    logic [8:0] hcnt = '0, vcnt = '0;
    logic       pal_mode = 1'b0, overscan = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       nmi_o, irq_o;

    always #2.5 clk = ~clk;

    raster_irq_ctrl u0 (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst_n(sys_rst_n),
        .hcnt(hcnt), .vcnt(vcnt), .pal_mode(pal_mode), .overscan(overscan),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_o(nmi_o), .irq_o(irq_o)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Expected-state mirror built from the requirements
    bit       m_en, m_vb, m_hb, m_nmi, m_irq, m_held;
    bit [1:0] m_mode;
    bit [8:0] m_ht = 9'h1FF, m_vt = 9'h1FF;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_rdata(logic [2:0] a);
        case (a)
            3'd5: return {m_nmi, 7'b0};
            3'd6: return {m_irq, 7'b0};
            3'd7: return {m_vb, m_hb, 6'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        bit [8:0] vst, vl;
        bit hh, vh, cond;
        if (!pwr_rst_n) begin m_ht = 9'h1FF; m_vt = 9'h1FF; end
        if (!pwr_rst_n || !sys_rst_n) begin
            m_en = 0; m_mode = 0; m_vb = 0; m_hb = 0;
            m_nmi = 0; m_irq = 0; m_held = 0;
            return;
        end
        vst  = overscan ? 9'd240 : 9'd225;
        vl   = pal_mode ? 9'd311 : 9'd261;
        hh   = (m_ht <= 9'd339) && (hcnt == m_ht);
        vh   = (m_vt <= vl) && (vcnt == m_vt);
        case (m_mode)
            2'd0: cond = 0;
            2'd1: cond = vh;
            2'd2: cond = hh;
            default: cond = hh && vh;
        endcase
        if (cond && !m_held) m_irq = 1;
        else if (bus_rd && bus_addr == 3'd6) m_irq = 0;
        m_held = cond;
        if (!m_vb && vcnt == vst) begin
            m_vb = 1; m_nmi = 1;
        end else begin
            if (bus_rd && bus_addr == 3'd5) m_nmi = 0;
            if (m_vb && vcnt == 0) begin m_vb = 0; m_nmi = 0; end
        end
        if (!m_hb && hcnt >= 9'd289) m_hb = 1;
        else if (m_hb && hcnt >= 9'd18 && hcnt < 9'd289) m_hb = 0;
        if (bus_wr) case (bus_addr)
            3'd0: begin m_en = bus_wdata[7]; m_mode = bus_wdata[1:0]; end
            3'd1: m_ht[7:0] = bus_wdata;
            3'd2: m_ht[8]   = bus_wdata[0];
            3'd3: m_vt[7:0] = bus_wdata;
            3'd4: m_vt[8]   = bus_wdata[0];
            default: ;
        endcase
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " nmi_o"}, {7'b0, nmi_o}, {7'b0, m_nmi & m_en});
        chk({tag, " irq_o"}, {7'b0, irq_o}, {7'b0, m_irq});
    endtask

    task automatic pos(int h, int v, string tag);
        hcnt = 9'(h); vcnt = 9'(v);
        tick(tag);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick("R7 write");
        bus_wr = 0;
    endtask

    task automatic wr_cmp(bit is_v, int val);
        wr(is_v ? 3'd3 : 3'd1, 8'(val));
        wr(is_v ? 3'd4 : 3'd2, {7'b0, 1'(val >> 8)});
    endtask

    // Read with the counters moved in the same cycle
    task automatic rd_at(logic [2:0] a, int h, int v, string tag);
        hcnt = 9'(h); vcnt = 9'(v);
        bus_rd = 1; bus_addr = a;
        #0.5;
        chk({tag, " rdata"}, bus_rdata, m_rdata(a));
        tick(tag);
        bus_rd = 0;
    endtask

    task automatic rd(logic [2:0] a, string tag);
        rd_at(a, int'(hcnt), int'(vcnt), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        tick("R13 power reset");
        tick("R13 power reset");
        pwr_rst_n = 1;
        // R13: everything idle, unused bits zero
        for (int a = 0; a < 8; a++) rd(3'(a), "R13 reset read");
        chk("R13 irq_o", {7'b0, irq_o}, 8'h00);

        // R6 / R7: power-on compare value 0x1FF never matches
        pos(0, 10, "R7 idle");
        wr(3'd0, 8'h02);
        for (int h = 0; h <= 339; h++) pos(h, 10, "R6 H sweep 1FF");
        chk("R6 no H irq", {7'b0, irq_o}, 8'h00);
        wr(3'd0, 8'h01); pal_mode = 1;
        for (int v = 0; v <= 311; v++) pos(5, v, "R6 V sweep 1FF");
        chk("R6 no V irq", {7'b0, irq_o}, 8'h00);
        pal_mode = 0;
        pos(5, 0, "R9 leave blank");
        rd(3'd5, "R9 clear");

        // R7: compare survives system reset
        wr_cmp(0, 100);
        sys_rst_n = 0; tick("R13 sys reset"); sys_rst_n = 1;
        rd(3'd0, "R13 enable cleared");
        pos(0, 10, "R7 park");
        wr(3'd0, 8'h02);
        pos(100, 10, "R7 kept htime");
        chk("R7 irq after sys reset", {7'b0, irq_o}, 8'h01);
        // R5: held match, read, no retrigger
        pos(100, 10, "R5 held");
        rd(3'd6, "R10 read irq");
        chk("R10 irq cleared", {7'b0, irq_o}, 8'h00);
        pos(100, 10, "R5 still held");
        chk("R5 no retrigger", {7'b0, irq_o}, 8'h00);
        // R3: next line fires again
        pos(101, 11, "R3 move");
        pos(100, 11, "R3 next line");
        chk("R3 fires each line", {7'b0, irq_o}, 8'h01);
        rd(3'd6, "R10 read");
        // R11: read coincides with fire
        pos(99, 12, "R11 setup");
        rd_at(3'd6, 100, 12, "R11 irq read vs set");
        chk("R11 irq kept", {7'b0, irq_o}, 8'h01);
        rd(3'd6, "R10 read");

        // R2: V line mode
        wr_cmp(1, 50);
        wr(3'd0, 8'h01);
        pos(7, 49, "R2 before");
        chk("R2 no early", {7'b0, irq_o}, 8'h00);
        pos(7, 50, "R2 line");
        chk("R2 fires", {7'b0, irq_o}, 8'h01);
        rd(3'd6, "R10 read");
        for (int h = 8; h < 20; h++) pos(h, 50, "R5 line held");
        chk("R5 once per line", {7'b0, irq_o}, 8'h00);

        // R4: combined
        wr(3'd0, 8'h03);
        pos(100, 49, "R4 wrong line");
        pos(99, 50, "R4 wrong dot");
        chk("R4 none yet", {7'b0, irq_o}, 8'h00);
        pos(100, 50, "R4 match");
        chk("R4 fires", {7'b0, irq_o}, 8'h01);
        rd(3'd6, "R10 read");

        // R6: V compare beyond the short range, then the long range
        wr_cmp(1, 300);
        wr(3'd0, 8'h01);
        pos(3, 299, "R6 ntsc"); pos(3, 300, "R6 ntsc");
        chk("R6 ntsc out of range", {7'b0, irq_o}, 8'h00);
        pal_mode = 1;
        pos(3, 299, "R6 pal"); pos(3, 300, "R6 pal");
        chk("R6 pal in range", {7'b0, irq_o}, 8'h01);
        rd(3'd6, "R10 read");
        pal_mode = 0;
        wr(3'd0, 8'h00);

        // R8 / R9: NMI flag without enable
        pos(3, 0, "R9 end blank");
        rd(3'd5, "R9 clear");
        pos(3, 224, "R8 before");
        pos(3, 225, "R8 start blank");
        chk("R8 masked", {7'b0, nmi_o}, 8'h00);
        rd(3'd7, "R12 vblank status");
        chk("R12 vblank bit", bus_rdata & 8'h80, 8'h80);
        rd(3'd5, "R8 flag without enable");
        rd(3'd5, "R9 cleared by read");
        chk("R9 cleared", bus_rdata, 8'h00);
        wr(3'd0, 8'h80);
        pos(3, 0, "R9 leave");
        pos(3, 225, "R8 enabled start");
        chk("R8 nmi_o high", {7'b0, nmi_o}, 8'h01);
        pos(3, 226, "R8 hold");
        pos(3, 0, "R9 end clears");
        chk("R9 end clears", {7'b0, nmi_o}, 8'h00);
        overscan = 1;
        pos(3, 225, "R8 overscan no set");
        chk("R8 overscan 225", {7'b0, nmi_o}, 8'h00);
        pos(3, 240, "R8 overscan 240");
        chk("R8 overscan 240", {7'b0, nmi_o}, 8'h01);
        pos(3, 0, "R9 end");
        overscan = 0;
        // R11: NMI read in the set cycle
        pos(3, 224, "R11 setup");
        rd_at(3'd5, 3, 225, "R11 nmi read vs set");
        chk("R11 nmi kept", {7'b0, nmi_o}, 8'h01);

        // R12: horizontal blank
        pos(288, 225, "R12 h before");
        pos(289, 225, "R12 h on");
        rd(3'd7, "R12 hblank set");
        chk("R12 hblank bit", bus_rdata & 8'h40, 8'h40);
        pos(18, 225, "R12 h off");
        rd(3'd7, "R12 hblank clear");
        chk("R12 hblank cleared", bus_rdata & 8'h40, 8'h00);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int h, v, r;
            if (i % 500 == 0) begin
                pal_mode = 1'($urandom_range(0, 1));
                overscan = 1'($urandom_range(0, 1));
            end
            case ($urandom_range(0, 4))
                0: h = (m_ht <= 339) ? int'(m_ht) : 0;
                1: h = (m_ht < 339) ? int'(m_ht) + 1 : 1;
                2: h = 289;
                3: h = 18;
                default: h = $urandom_range(0, 339);
            endcase
            case ($urandom_range(0, 5))
                0: v = (m_vt <= 311) ? int'(m_vt) : 0;
                1: v = 0;
                2: v = 225;
                3: v = 240;
                4: v = int'(vcnt);
                default: v = $urandom_range(0, pal_mode ? 311 : 261);
            endcase
            r = $urandom_range(0, 15);
            if (r == 0) begin
                hcnt = 9'(h); vcnt = 9'(v);
                wr(3'd0, 8'($urandom_range(0, 255)));
            end else if (r <= 2) begin
                hcnt = 9'(h); vcnt = 9'(v);
                wr(3'($urandom_range(1, 4)), 8'($urandom_range(0, 255)));
            end else if (r <= 5) begin
                rd_at(3'($urandom_range(5, 7)), h, v, "R11 R12 random read");
            end else begin
                pos(h, v, "R2 R3 R4 R8 random");
            end
        end
        finish_run();
    end
endmodule